// File: doc/BRIEF.md
# Interrupt Register Bank Allocator

This block decides where the processor context goes when an exception is entered. It keeps a pointer to the next free save bank out of fifteen (numbered 0 to 14). Only maskable interrupt entries with bank usage enabled are candidates for a bank save. For such an entry it issues a one-cycle save strobe carrying the bank number and the vector table offset of the interrupt, and then advances the pointer. NMI, address-error and instruction-caused entries always leave context saving to the memory stack, so the block does nothing for them. A bank save covers R0–R14, GBR, MACH, MACL, PR and the vector offset; the register file is written elsewhere.

A maskable entry can arrive when all fifteen banks are occupied. An overflow-exception-enable input then chooses the result. With the input low, the block raises a one-cycle stack-fallback flag. With it high, the block signals a bank overflow exception instead. The block keeps a flag for every accepted maskable nesting level that records whether that level used a bank. A restore request pops the innermost level, and it frees a bank only if that level took one. A restore with no recorded level is reported as an error.

Top module: `irq_bank_alloc`

## Requirements
- R1: After reset the bank pointer is 0 and the strobes save_o, stack_fb_o, ovf_exc_o, restore_o and restore_err_o are all low.
- R2: An entry with kind code 2'b00 (maskable), bank_en_i high and pointer below 15 gives save_o high on the next cycle, with save_bank_o equal to the old pointer and save_vec_o equal to the entry's vector offset. The pointer rises by one.
- R3: Entries with kind code 2'b01 (NMI), 2'b10 (address error) or 2'b11 (instruction) raise no save, fallback or overflow strobe and leave the pointer unchanged.
- R4: A maskable entry with bank_en_i low raises no strobe and leaves the pointer unchanged.
- R5: A maskable entry with bank usage enabled, pointer at 15 and ovf_exc_en_i low gives stack_fb_o high on the next cycle. The pointer stays at 15.
- R6: The same entry with ovf_exc_en_i high gives ovf_exc_o high on the next cycle, leaves the pointer unchanged and records no nesting level.
- R7: A restore whose innermost level used a bank gives restore_o high on the next cycle, with restore_bank_o equal to the pointer minus one. The pointer then decreases by one.
- R8: A restore whose innermost level did not use a bank (fallback or banks disabled) discards that level without restore_o and without changing the pointer.
- R9: A restore with no recorded level gives restore_err_o high on the next cycle. The pointer stays at 0.
- R10: When entry_valid_i and restore_i are high together, the restore is ignored and only the entry is processed.
- R11: Every strobe lasts one cycle per event, and at most one of the five strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| entry_valid_i | input | 1 | Exception entry event this cycle |
| entry_kind_i | input | 2 | 00 maskable, 01 NMI, 10 address error, 11 instruction |
| entry_vec_i | input | VEC_W | Vector table offset of the entry |
| bank_en_i | input | 1 | Bank usage enabled |
| ovf_exc_en_i | input | 1 | Raise an overflow exception instead of falling back to the stack |
| restore_i | input | 1 | Restore request from interrupt return |
| save_o | output | 1 | Bank save strobe |
| save_bank_o | output | BANK_W | Bank to save into |
| save_vec_o | output | VEC_W | Vector offset to store with the bank |
| stack_fb_o | output | 1 | Banks full, context goes to the stack |
| ovf_exc_o | output | 1 | Bank overflow exception |
| restore_o | output | 1 | Bank restore strobe |
| restore_bank_o | output | BANK_W | Bank to restore from |
| restore_err_o | output | 1 | Restore with nothing to pop |
| bank_ptr_o | output | PTR_W | Number of banks in use |

## Verification
Directed sequences fill all fifteen banks and then run into both full-bank outcomes. They then unwind through a fallback level, every bank level and an empty stack. This separates bank pops from stack-only pops and from the error case. Separate directed entries of each non-maskable kind and of a maskable kind with banks disabled show that only the maskable, enabled combination touches the pointer. A collision of entry and restore shows which of the two wins. Seeded random traffic then mixes kinds, enables and restores, so that interleaved bank-disabled levels among bank levels check the per-level flags against a reference model.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  typedef enum logic [1:0] {
    EK_IRQ      = 2'b00,
    EK_NMI      = 2'b01,
    EK_ADDR_ERR = 2'b10,
    EK_INSTR    = 2'b11
  } entry_kind_e;

  typedef struct packed {
    logic bank;   // save into next bank
    logic fb;     // banks full, stack fallback
    logic ovf;    // banks full, overflow exception
    logic push;   // record a nesting level
  } entry_dec_t;
endpackage

// File: rtl/ibk_decide.sv
module ibk_decide
  import irq_bank_pkg::*;
#(
  parameter int NUM_BANKS = 15,
  localparam int PTR_W = $clog2(NUM_BANKS + 1)
) (
  input  logic             entry_valid_i,
  input  entry_kind_e      entry_kind_i,
  input  logic             bank_en_i,
  input  logic             ovf_exc_en_i,
  input  logic [PTR_W-1:0] ptr_i,
  output entry_dec_t       dec_o
);
  logic is_irq, full;

  always_comb begin
    is_irq    = entry_valid_i && (entry_kind_i == EK_IRQ);
    full      = (ptr_i == PTR_W'(NUM_BANKS));
    dec_o.bank = is_irq && bank_en_i && !full;
    dec_o.fb   = is_irq && bank_en_i && full && !ovf_exc_en_i;
    dec_o.ovf  = is_irq && bank_en_i && full && ovf_exc_en_i;
    dec_o.push = is_irq && !dec_o.ovf;
  end
endmodule

// File: rtl/ibk_lvl_stack.sv
module ibk_lvl_stack #(
  parameter int LVL_DEPTH = 32,
  localparam int LVL_W = $clog2(LVL_DEPTH + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic push_i,
  input  logic push_bank_i,
  input  logic pop_i,
  output logic empty_o,
  output logic top_bank_o
);
  logic [LVL_W-1:0]     depth_q;
  logic [LVL_DEPTH-1:0] flag_q;
  logic                 full;

  assign empty_o = (depth_q == '0);
  assign full    = (depth_q == LVL_W'(LVL_DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) depth_q <= '0;
    else if (push_i && !full) depth_q <= depth_q + 1'b1;
    else if (pop_i && !empty_o) depth_q <= depth_q - 1'b1;
  end

  for (genvar g = 0; g < LVL_DEPTH; g++) begin : g_lvl
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q[g] <= 1'b0;
      else if (push_i && depth_q == LVL_W'(g)) flag_q[g] <= push_bank_i;
    end
  end

  always_comb begin
    top_bank_o = 1'b0;
    for (int i = 0; i < LVL_DEPTH; i++)
      if (depth_q == LVL_W'(i + 1)) top_bank_o = flag_q[i];
  end

  // R8: a pop never runs below an empty stack
  a_r8_no_pop_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o && pop_i |=> empty_o);
  a_r10_no_push_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_i && pop_i));
endmodule

// File: rtl/ibk_ptr.sv
module ibk_ptr #(
  parameter int NUM_BANKS = 15,
  localparam int PTR_W = $clog2(NUM_BANKS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [PTR_W-1:0] ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_o <= '0;
    else if (inc_i) ptr_o <= ptr_o + 1'b1;
    else if (dec_i) ptr_o <= ptr_o - 1'b1;
  end

  a_r2_no_inc_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |-> ptr_o < PTR_W'(NUM_BANKS));
  a_r7_no_dec_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> ptr_o != '0);
  a_r1_ptr_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_o <= PTR_W'(NUM_BANKS));
endmodule

// File: rtl/irq_bank_alloc.sv
module irq_bank_alloc
  import irq_bank_pkg::*;
#(
  parameter int NUM_BANKS = 15,
  parameter int LVL_DEPTH = 32,
  parameter int VEC_W     = 10,
  localparam int PTR_W    = $clog2(NUM_BANKS + 1),
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              entry_valid_i,
  input  logic [1:0]        entry_kind_i,
  input  logic [VEC_W-1:0]  entry_vec_i,
  input  logic              bank_en_i,
  input  logic              ovf_exc_en_i,
  input  logic              restore_i,
  output logic              save_o,
  output logic [BANK_W-1:0] save_bank_o,
  output logic [VEC_W-1:0]  save_vec_o,
  output logic              stack_fb_o,
  output logic              ovf_exc_o,
  output logic              restore_o,
  output logic [BANK_W-1:0] restore_bank_o,
  output logic              restore_err_o,
  output logic [PTR_W-1:0]  bank_ptr_o
);
  entry_dec_t       dec;
  logic             pop_req, lvl_empty, top_bank, do_rst_bank, do_err;
  logic [PTR_W-1:0] ptr_m1;

  ibk_decide #(.NUM_BANKS(NUM_BANKS)) u_decide (
    .entry_valid_i(entry_valid_i),
    .entry_kind_i (entry_kind_e'(entry_kind_i)),
    .bank_en_i    (bank_en_i),
    .ovf_exc_en_i (ovf_exc_en_i),
    .ptr_i        (bank_ptr_o),
    .dec_o        (dec)
  );

  // entry wins over a colliding restore
  assign pop_req     = restore_i && !entry_valid_i;
  assign do_rst_bank = pop_req && !lvl_empty && top_bank;
  assign do_err      = pop_req && lvl_empty;
  assign ptr_m1      = bank_ptr_o - 1'b1;

  ibk_lvl_stack #(.LVL_DEPTH(LVL_DEPTH)) u_lvl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (dec.push),
    .push_bank_i(dec.bank),
    .pop_i      (pop_req),
    .empty_o    (lvl_empty),
    .top_bank_o (top_bank)
  );

  ibk_ptr #(.NUM_BANKS(NUM_BANKS)) u_ptr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (dec.bank),
    .dec_i (do_rst_bank),
    .ptr_o (bank_ptr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      save_o         <= 1'b0;
      save_bank_o    <= '0;
      save_vec_o     <= '0;
      stack_fb_o     <= 1'b0;
      ovf_exc_o      <= 1'b0;
      restore_o      <= 1'b0;
      restore_bank_o <= '0;
      restore_err_o  <= 1'b0;
    end else begin
      save_o        <= dec.bank;
      stack_fb_o    <= dec.fb;
      ovf_exc_o     <= dec.ovf;
      restore_o     <= do_rst_bank;
      restore_err_o <= do_err;
      if (dec.bank) begin
        save_bank_o <= BANK_W'(bank_ptr_o);
        save_vec_o  <= entry_vec_i;
      end
      if (do_rst_bank) restore_bank_o <= BANK_W'(ptr_m1);
    end
  end

  a_r3_nonmask_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_valid_i && entry_kind_i != 2'b00 |=>
      !save_o && !stack_fb_o && !ovf_exc_o && bank_ptr_o == $past(bank_ptr_o));
  a_r4_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_valid_i && !bank_en_i |=> !save_o && !stack_fb_o && !ovf_exc_o);
  a_r2_save_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_valid_i && entry_kind_i == 2'b00 && bank_en_i &&
    bank_ptr_o < PTR_W'(NUM_BANKS) |=>
      save_o && bank_ptr_o == $past(bank_ptr_o) + 1'b1);
  a_r5_fallback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_valid_i && entry_kind_i == 2'b00 && bank_en_i && !ovf_exc_en_i &&
    bank_ptr_o == PTR_W'(NUM_BANKS) |=> stack_fb_o && $stable(bank_ptr_o));
  a_r6_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_valid_i && entry_kind_i == 2'b00 && bank_en_i && ovf_exc_en_i &&
    bank_ptr_o == PTR_W'(NUM_BANKS) |=> ovf_exc_o && $stable(bank_ptr_o));
  a_r9_err_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_err_o |-> bank_ptr_o == '0);
  a_r10_entry_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_valid_i && restore_i |=> !restore_o && !restore_err_o);
  a_r11_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({save_o, stack_fb_o, ovf_exc_o, restore_o, restore_err_o}));
endmodule

// File: tb/sim_irq_bank_alloc.sv
module sim_irq_bank_alloc;
  localparam int NB = 15;
  localparam int LD = 32;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       ev = 1'b0, ben = 1'b0, oen = 1'b0, rs = 1'b0;
  logic [1:0] kind = 2'b00;
  logic [9:0] vec = '0;
  logic       save, fb, ovf, rst_b, err;
  logic [3:0] sbank, rbank, ptr;
  logic [9:0] svec;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  int m_ptr = 0, m_depth = 0;
  bit m_flag [LD];

  always #2 clk = ~clk;

  irq_bank_alloc u0 (
    .clk_i(clk), .rst_ni(rst_n), .entry_valid_i(ev), .entry_kind_i(kind),
    .entry_vec_i(vec), .bank_en_i(ben), .ovf_exc_en_i(oen), .restore_i(rs),
    .save_o(save), .save_bank_o(sbank), .save_vec_o(svec), .stack_fb_o(fb),
    .ovf_exc_o(ovf), .restore_o(rst_b), .restore_bank_o(rbank),
    .restore_err_o(err), .bank_ptr_o(ptr)
  );

  function automatic string tag_of(bit v, bit [1:0] k, bit be, bit oe, bit r, int p, int d);
    if (v && r) return "R10";
    if (v && k != 2'b00) return "R3";
    if (v && !be) return "R4";
    if (v && p < NB) return "R2";
    if (v) return oe ? "R6" : "R5";
    if (r && d == 0) return "R9";
    if (r) return m_flag[d-1] ? "R7" : "R8";
    return "R11";
  endfunction

  task automatic step(bit v, bit [1:0] k, bit be, bit oe, bit [9:0] vv, bit r);
    bit e_save = 0, e_fb = 0, e_ovf = 0, e_rst = 0, e_err = 0;
    int e_sb = 0, e_rb = 0;
    string tag;
    bit bad;
    tag = tag_of(v, k, be, oe, r, m_ptr, m_depth);
    ev = v; kind = k; ben = be; oen = oe; vec = vv; rs = r;
    if (v) begin
      if (k == 2'b00) begin
        if (be && m_ptr < NB) begin
          e_save = 1; e_sb = m_ptr; m_ptr++;
          if (m_depth < LD) begin m_flag[m_depth] = 1; m_depth++; end
        end else if (be && oe) begin
          e_ovf = 1;
        end else begin
          e_fb = be;
          if (m_depth < LD) begin m_flag[m_depth] = 0; m_depth++; end
        end
      end
    end else if (r) begin
      if (m_depth == 0) e_err = 1;
      else begin
        m_depth--;
        if (m_flag[m_depth]) begin e_rst = 1; e_rb = m_ptr - 1; m_ptr--; end
      end
    end
    @(negedge clk);
    ev = 0; rs = 0;
    n_vec++;
    bad = (save != e_save) || (fb != e_fb) || (ovf != e_ovf) || (rst_b != e_rst) ||
          (err != e_err) || (int'(ptr) != m_ptr) ||
          (e_save && (int'(sbank) != e_sb || svec != vv)) ||
          (e_rst && int'(rbank) != e_rb);
    if (bad) begin
      n_bad++;
      $display("FAIL %s: got save=%0b bank=%0d vec=%0d fb=%0b ovf=%0b rst=%0b rbank=%0d err=%0b ptr=%0d exp save=%0b bank=%0d vec=%0d fb=%0b ovf=%0b rst=%0b rbank=%0d err=%0b ptr=%0d",
               tag, save, sbank, svec, fb, ovf, rst_b, rbank, err, ptr,
               e_save, e_sb, vv, e_fb, e_ovf, e_rst, e_rb, e_err, m_ptr);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung run, exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    bit v, be, oe, r;
    bit [1:0] k;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    // R1 reset state
    n_vec++;
    if (ptr != 0 || save || fb || ovf || rst_b || err) begin
      n_bad++;
      $display("FAIL R1: got ptr=%0d strobes=%b exp ptr=0 strobes=00000", ptr,
               {save, fb, ovf, rst_b, err});
    end
    rst_n = 1'b1;
    @(negedge clk);
    step(1, 2'b00, 0, 0, 10'd5, 0);           // R4 banks disabled
    step(0, 2'b00, 1, 0, 10'd0, 1);           // R8 pop stack-only level
    step(1, 2'b01, 1, 0, 10'd7, 0);           // R3 NMI
    step(1, 2'b10, 1, 1, 10'd8, 0);           // R3 address error
    step(1, 2'b11, 1, 0, 10'd9, 0);           // R3 instruction
    for (int i = 0; i < NB; i++) step(1, 2'b00, 1, 0, 10'(100 + i), 0); // R2 fill
    step(1, 2'b00, 1, 0, 10'd200, 0);         // R5 fallback
    step(1, 2'b00, 1, 1, 10'd201, 0);         // R6 overflow
    step(1, 2'b01, 1, 0, 10'd202, 1);         // R10 collision
    step(0, 2'b00, 1, 0, 10'd0, 1);           // R8 pop fallback level
    for (int i = 0; i < NB; i++) step(0, 2'b00, 1, 0, 10'd0, 1); // R7 drain
    step(0, 2'b00, 1, 0, 10'd0, 1);           // R9 empty restore
    step(0, 2'b00, 1, 0, 10'd0, 0);           // R11 idle
    for (int i = 0; i < 1500; i++) begin
      v  = ($urandom % 100) < 55;
      k  = (($urandom % 100) < 65) ? 2'b00 : 2'($urandom % 4);
      be = ($urandom % 100) < 85;
      oe = ($urandom % 100) < 30;
      r  = ($urandom % 100) < 40;
      if (m_depth >= LD - 2) begin v = 0; r = 1; end
      step(v, k, be, oe, 10'($urandom), r);
    end
    while (m_depth > 0) step(0, 2'b00, 1, 0, 10'd0, 1);
    step(0, 2'b00, 1, 0, 10'd0, 1);           // R9 after random
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule